// File: doc/BRIEF.md
# Multi-Channel I/Q Word Interleaver

This block takes baseband complex samples from up to four receive channels that all run at one common sample rate. It turns them into a single stream of 16-bit signed words for a host transport. On one shared sample strobe, every active channel's in-phase and quadrature values are captured together as one frame. Each frame goes into a small frame buffer. The buffer absorbs the burst of words that each strobe produces while the downstream consumer drains them.

The output is a valid/ready word stream. Every frame starts with the in-phase word of channel 0. For each channel the in-phase word comes before the quadrature word, and channels are emitted in ascending order. With four channels the cycle is I0 Q0 I1 Q1 I2 Q2 I3 Q3, and then it repeats. Each complex sample therefore costs two words, or four bytes.

Software selects 1, 2 or 4 active channels with a write strobe. Any other value is ignored. A new count applies only to frames captured after the write, so a frame already buffered keeps the count it was captured with. If a strobe arrives while the buffer is full, that frame is dropped whole and a sticky overrun flag is raised.

Top module: `iq_interleaver`

## Requirements
- R1: After reset, `out_valid` and `overrun` are 0 and the channel count is 1, so each frame yields 2 words.
- R2: Within a frame, word k carries channel k/2. It is the in-phase value when k is even and the quadrature value when k is odd, and the channel index rises from 0.
- R3: Writing 1, 2 or 4 on `cnt_val` with `cnt_wr` high sets the channel count n, and each later frame yields exactly 2n words.
- R4: Writing any other value (0, 3, 5, 6, 7) on `cnt_val` leaves the previous channel count unchanged.
- R5: One `smp_valid` strobe captures all active channels at once. Values on inactive channel inputs never appear on the output.
- R6: A count change affects only frames captured after the write cycle. Frames already buffered keep their own count, and every frame begins at the channel 0 in-phase word.
- R7: The buffer holds `FRAMES` (default 2) whole frames. A strobe while it is full drops that frame completely and sets `overrun`, which stays 1 until reset.
- R8: A word leaves only on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` does not change.
- R9: When the buffer is empty, a strobe captured at a clock edge makes `out_valid` high with the channel 0 in-phase word right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr | input | 1 | Channel-count write strobe |
| cnt_val | input | 3 | Requested channel count (1, 2 or 4) |
| smp_valid | input | 1 | Shared sample strobe for all channels |
| smp_i | input | NCH_MAX*W (64) | In-phase inputs, channel c at bits c*W upward |
| smp_q | input | NCH_MAX*W (64) | Quadrature inputs, channel c at bits c*W upward |
| out_data | output | W (16) | Output word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| overrun | output | 1 | Sticky frame-drop flag |

## Verification
There is no pipeline between the frame buffer and the output. A strobe captured at an edge makes its first word visible right after that edge, and the frame drop and the overrun flag also show up right after the strobe's edge. A count write likewise applies from the edge that samples it. The bench changes inputs a short delay after each rising edge and reads outputs at the falling edge, so every check sees settled values for the upcoming edge. Each expected word is pushed onto a queue when its frame is sent. The check pops the queue on each cycle the falling-edge sample shows a handshake, and stalled cycles are compared against the word held on the previous sample.

// File: rtl/iq_ilv_pkg.sv
package iq_ilv_pkg;
   // log2 of the active channel count: 0 -> 1, 1 -> 2, 2 -> 4
   typedef logic [1:0] ncode_t;

   function automatic int ncode_words(ncode_t c);
      return 2 << c;
   endfunction
endpackage

// File: rtl/iq_ilv_cfg.sv
module iq_ilv_cfg
   import iq_ilv_pkg::*;
#(
   parameter int NCH_MAX = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [2:0] val,
   output ncode_t     code
);
   logic   legal;
   ncode_t enc;

   always_comb begin
      legal = 1'b0;
      enc   = 2'd0;
      case (val)
         3'd1: begin legal = 1'b1;          enc = 2'd0; end
         3'd2: begin legal = (NCH_MAX >= 2); enc = 2'd1; end
         3'd4: begin legal = (NCH_MAX >= 4); enc = 2'd2; end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         code <= 2'd0;
      else if (wr && legal)
         code <= enc;
   end

   // R3
   cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ncode_words(code) <= 2 * NCH_MAX);

   // R4
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(code));
endmodule

// File: rtl/iq_ilv_fbuf.sv
module iq_ilv_fbuf #(
   parameter int DW     = 130,
   parameter int FRAMES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          full,
   output logic          empty
);
   localparam int PTR_W = $clog2(FRAMES);
   localparam int CNT_W = $clog2(FRAMES + 1);

   logic [DW-1:0]    mem [FRAMES];
   logic [PTR_W-1:0] wp, rp;
   logic [CNT_W-1:0] cnt;

   assign full  = (cnt == CNT_W'(FRAMES));
   assign empty = (cnt == '0);
   assign dout  = mem[rp];

   always_ff @(posedge clk) begin
      if (push)
         mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: ;
         endcase
      end
   end

   // R7
   fbuf_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R7
   fbuf_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/iq_ilv_ser.sv
module iq_ilv_ser
   import iq_ilv_pkg::*;
#(
   parameter int W       = 16,
   parameter int NCH_MAX = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   avail,
   input  ncode_t                 code,
   input  logic [2*NCH_MAX*W-1:0] frame,
   input  logic                   ready,
   output logic [W-1:0]           data,
   output logic                   valid,
   output logic                   pop
);
   localparam int WPF  = 2 * NCH_MAX;
   localparam int IW   = (WPF > 1) ? $clog2(WPF) : 1;

   logic [W-1:0]  words [WPF];
   logic [IW-1:0] idx;
   logic [IW-1:0] last;

   for (genvar g = 0; g < WPF; g++) begin : g_word
      assign words[g] = frame[g*W +: W];
   end

   assign last  = IW'(ncode_words(code) - 1);
   assign valid = avail;
   assign data  = words[idx];
   assign pop   = valid && ready && (idx == last);

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx <= '0;
      else if (valid && ready)
         idx <= (idx == last) ? '0 : idx + 1'b1;
   end

   // R8
   ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable(data));

   // R6
   ser_frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> idx == '0);

   // R6
   ser_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= last);
endmodule

// File: rtl/iq_interleaver.sv
module iq_interleaver
   import iq_ilv_pkg::*;
#(
   parameter int W       = 16,
   parameter int NCH_MAX = 4,
   parameter int FRAMES  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cnt_wr,
   input  logic [2:0]           cnt_val,
   input  logic                 smp_valid,
   input  logic [NCH_MAX*W-1:0] smp_i,
   input  logic [NCH_MAX*W-1:0] smp_q,
   output logic [W-1:0]         out_data,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic                 overrun
);
   localparam int WPF = 2 * NCH_MAX;
   localparam int FW  = WPF * W;
   localparam int DW  = FW + $bits(ncode_t);

   if (NCH_MAX != 1 && NCH_MAX != 2 && NCH_MAX != 4) begin : g_bad_nch
      $error("NCH_MAX must be 1, 2 or 4");
   end
   if (FRAMES < 2 || (FRAMES & (FRAMES - 1)) != 0) begin : g_bad_frames
      $error("FRAMES must be a power of two, at least 2");
   end
   if (W < 2) begin : g_bad_w
      $error("W must be at least 2");
   end

   ncode_t        code_cur, code_head;
   logic [FW-1:0] frame_in, frame_head;
   logic [DW-1:0] buf_out;
   logic          buf_full, buf_empty, push, pop;

   // word 2c is channel c in-phase, word 2c+1 its quadrature
   for (genvar c = 0; c < NCH_MAX; c++) begin : g_pack
      assign frame_in[(2*c)*W   +: W] = smp_i[c*W +: W];
      assign frame_in[(2*c+1)*W +: W] = smp_q[c*W +: W];
   end

   iq_ilv_cfg #(.NCH_MAX(NCH_MAX)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cnt_wr),
      .val   (cnt_val),
      .code  (code_cur)
   );

   assign push = smp_valid && !buf_full;

   iq_ilv_fbuf #(.DW(DW), .FRAMES(FRAMES)) u_fbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   ({code_cur, frame_in}),
      .pop   (pop),
      .dout  (buf_out),
      .full  (buf_full),
      .empty (buf_empty)
   );

   assign code_head  = buf_out[DW-1 -: $bits(ncode_t)];
   assign frame_head = buf_out[FW-1:0];

   iq_ilv_ser #(.W(W), .NCH_MAX(NCH_MAX)) u_ser (
      .clk   (clk),
      .rst_n (rst_n),
      .avail (!buf_empty),
      .code  (code_head),
      .frame (frame_head),
      .ready (out_ready),
      .data  (out_data),
      .valid (out_valid),
      .pop   (pop)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         overrun <= 1'b0;
      else if (smp_valid && buf_full)
         overrun <= 1'b1;
   end

   // R7
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R7
   overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !overrun && !(smp_valid && buf_full) |=> !overrun);

   // R9
   first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid && smp_valid |=> out_valid && out_data == $past(smp_i[W-1:0]));
endmodule

// File: tb/test_iq_interleaver.sv
module test_iq_interleaver;
   localparam int W = 16;
   localparam int N = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cnt_wr = 1'b0;
   logic [2:0]     cnt_val = 3'd0;
   logic           smp_valid = 1'b0;
   logic [N*W-1:0] smp_i = '0;
   logic [N*W-1:0] smp_q = '0;
   logic [W-1:0]   out_data;
   logic           out_valid;
   logic           out_ready = 1'b0;
   logic           overrun;

   int             n_chk = 0;
   int             n_fail = 0;
   int             rdy_mode = 0;
   int             cyc = 0;
   string          cur_req = "R2";
   logic [W-1:0]   exp_q [$];
   logic           held_v = 1'b0;
   logic [W-1:0]   held_d = '0;

   iq_interleaver #(.W(W), .NCH_MAX(N), .FRAMES(2)) i_iq_interleaver (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_wr    (cnt_wr),
      .cnt_val   (cnt_val),
      .smp_valid (smp_valid),
      .smp_i     (smp_i),
      .smp_q     (smp_q),
      .out_data  (out_data),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .overrun   (overrun)
   );

   always #5 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic [W-1:0] val_i(int c, int f);
      return W'((c << 12) | (f & 12'hfff));
   endfunction

   function automatic logic [W-1:0] val_q(int c, int f);
      return W'(16'h8000 | (c << 12) | ((f * 3) & 12'hfff));
   endfunction

   // ready pattern: 0 always, 1 every other cycle, 2 one in three, 3 never
   always @(posedge clk) begin
      cyc++;
      #2;
      case (rdy_mode)
         0: out_ready = 1'b1;
         1: out_ready = cyc[0];
         2: out_ready = (cyc % 3 == 0);
         default: out_ready = 1'b0;
      endcase
   end

   // output monitor at falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (held_v)
            check("R8 stall hold", {15'd0, out_valid, out_data}, {15'd0, 1'b1, held_d});
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0)
               check({cur_req, " unexpected word"}, {16'd0, out_data}, 32'hdead);
            else
               check({cur_req, " word"}, {16'd0, out_data}, {16'd0, exp_q.pop_front()});
         end
         held_v = out_valid && !out_ready;
         held_d = out_data;
      end else
         held_v = 1'b0;
   end

   task automatic set_cnt(input int n);
      @(posedge clk); #2;
      cnt_val = 3'(n);
      cnt_wr  = 1'b1;
      @(posedge clk); #2;
      cnt_wr  = 1'b0;
   endtask

   // n_exp: channels expected to be emitted; keep=0 means the frame is dropped
   task automatic send_frame(input int f, input int n_exp, input bit keep);
      @(posedge clk); #2;
      for (int c = 0; c < N; c++) begin
         smp_i[c*W +: W] = val_i(c, f);
         smp_q[c*W +: W] = val_q(c, f);
      end
      smp_valid = 1'b1;
      if (keep)
         for (int c = 0; c < n_exp; c++) begin
            exp_q.push_back(val_i(c, f));
            exp_q.push_back(val_q(c, f));
         end
      @(posedge clk); #2;
      smp_valid = 1'b0;
   endtask

   task automatic drain(input string req);
      int t = 0;
      while ((exp_q.size() != 0 || out_valid) && t < 3000) begin
         @(negedge clk);
         t++;
      end
      check({req, " drained"}, exp_q.size(), 0);
      @(negedge clk);
      check({req, " idle"}, {31'd0, out_valid}, 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #1500000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 valid", {31'd0, out_valid}, 0);
      check("R1 overrun", {31'd0, overrun}, 0);
      cur_req = "R1";
      rdy_mode = 0;
      send_frame(1, 1, 1'b1);
      drain("R1");

      // R3 / R5 two channels, inactive inputs carry data
      cur_req = "R5";
      set_cnt(2);
      for (int f = 2; f < 6; f++) begin
         rdy_mode = f % 3;
         send_frame(f, 2, 1'b1);
         drain("R5");
      end

      // R2 / R3 four channels under each ready pattern
      cur_req = "R2";
      set_cnt(4);
      for (int m = 0; m < 3; m++) begin
         rdy_mode = m;
         send_frame(10 + m, 4, 1'b1);
         send_frame(20 + m, 4, 1'b1);
         drain("R3");
      end

      // R4 illegal values keep four channels
      cur_req = "R4";
      rdy_mode = 0;
      for (int v = 0; v < 8; v++) begin
         if (v != 1 && v != 2 && v != 4) begin
            set_cnt(v);
            send_frame(30 + v, 4, 1'b1);
            drain("R4");
         end
      end
      set_cnt(1);
      cur_req = "R3";
      send_frame(40, 1, 1'b1);
      drain("R3");

      // R9 latency, R6 count change at frame boundary
      cur_req = "R6";
      set_cnt(4);
      rdy_mode = 3;
      send_frame(50, 4, 1'b1);
      @(negedge clk);
      check("R9 valid after strobe", {31'd0, out_valid}, 1);
      check("R9 first word", {16'd0, out_data}, {16'd0, val_i(0, 50)});
      set_cnt(1);
      send_frame(51, 1, 1'b1);
      rdy_mode = 1;
      drain("R6");

      // R7 overrun drops the third frame and stays set
      cur_req = "R7";
      set_cnt(2);
      rdy_mode = 3;
      send_frame(60, 2, 1'b1);
      send_frame(61, 2, 1'b1);
      @(negedge clk);
      check("R7 no overrun yet", {31'd0, overrun}, 0);
      send_frame(62, 2, 1'b0);
      @(negedge clk);
      check("R7 overrun set", {31'd0, overrun}, 1);
      rdy_mode = 0;
      drain("R7");
      check("R7 overrun held", {31'd0, overrun}, 1);
      send_frame(63, 2, 1'b1);
      drain("R7");
      check("R7 overrun still held", {31'd0, overrun}, 1);

      finish_run();
   end
endmodule